// File: doc/BRIEF.md
# GPIO Bank Interrupt Event Detector

This block watches the input lines of one GPIO bank and turns selected line activity into interrupt events. Each line carries a 3-bit event select, supplied by that line's configuration register. The select picks a falling edge, a rising edge, either edge, a low level or a high level. A detected event sets the line's bit in a status register. A mask register gates which status bits may raise the single interrupt request shared by the whole bank.

Software controls the mask through two write-only registers. Writing ones to the enable register sets mask bits, and writing ones to the disable register clears them. Software finds the pending lines by reading the status register and ANDing it with the mask. A status read returns the pending bits and clears them in the same access, so no acknowledge write is needed. Line values arrive already synchronized, and no input filtering is done here.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset the mask register, the status register and `irq_o` are all zero.
- R2: A write to offset 0x20 sets each mask bit whose write-data bit is 1 and leaves every other mask bit unchanged. The mask reads back at offset 0x28.
- R3: A write to offset 0x24 clears each mask bit whose write-data bit is 1 and leaves every other mask bit unchanged.
- R4: For line i, the select is `evt_sel_i[3i+2:3i]`. Code 0 sets status bit i on a 1-to-0 transition of the line. Code 1 sets it on a 0-to-1 transition. Code 2 sets it on any transition. The status bit sets on the clock edge that follows the cycle in which the line shows its new value.
- R5: Code 3 sets status bit i on every clock edge at which line i is 0, and code 4 does the same while the line is 1. A level that persists therefore sets the bit again right after a status read has cleared it.
- R6: Select codes 5, 6 and 7 never set a status bit.
- R7: A read at offset 0x2C returns the status register and clears it at the same clock edge. An event that arrives in the read cycle is still recorded.
- R8: `irq_o` is a register. It is high in the cycle after one in which status AND mask is non-zero, and low in the cycle after one in which that result is zero. A status bit whose mask bit is 0 never raises it.
- R9: No edge event is produced in the first cycle after reset is released, whatever the line levels.
- R10: Writes to offsets 0x28 and 0x2C change nothing. Reads from offsets 0x20, 0x24 and any unused offset return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | NUM_LINES | Synchronized line levels |
| evt_sel_i | input | 3*NUM_LINES | Per-line event select, line i at bits 3i+2:3i |
| bus_req_i | input | 1 | Register access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | 6 | Byte offset within the bank |
| bus_wdata_i | input | NUM_LINES | Write data, one bit per line |
| bus_rdata_o | output | NUM_LINES | Read data, valid combinationally during a read strobe |
| irq_o | output | 1 | Bank interrupt request |

## Verification
The bench builds the block with NUM_LINES set to 4. This makes it practical to sweep every line, every one of the eight select codes and every pair of previous and current line levels. For each vector it checks the exact status bit, the interrupt cycle that follows, and the return to idle. Directed sequences cover the corner cases: the first cycle after reset, an event arriving during the clearing read, a level that re-arms, unmasked status, and accesses that must have no effect.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  typedef enum logic [2:0] {
    EV_FALL = 3'd0,
    EV_RISE = 3'd1,
    EV_BOTH = 3'd2,
    EV_LOW  = 3'd3,
    EV_HIGH = 3'd4
  } ev_sel_e;

  localparam int unsigned REG_AW = 6;
  localparam int unsigned SEL_W  = 3;

  localparam logic [REG_AW-1:0] OFS_EN   = 6'h20;
  localparam logic [REG_AW-1:0] OFS_DIS  = 6'h24;
  localparam logic [REG_AW-1:0] OFS_MASK = 6'h28;
  localparam logic [REG_AW-1:0] OFS_STAT = 6'h2C;
endpackage

// File: rtl/gpio_evt_line.sv
module gpio_evt_line
  import gpio_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             evt_o
);
  logic prev_q;
  logic prime_q;  // prev_q holds a real sample
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      prime_q <= 1'b0;
    end else begin
      prev_q  <= line_i;
      prime_q <= 1'b1;
    end
  end

  assign rise = prime_q & ~prev_q & line_i;
  assign fall = prime_q & prev_q & ~line_i;

  always_comb begin
    case (sel_i)
      EV_FALL: evt_o = fall;
      EV_RISE: evt_o = rise;
      EV_BOTH: evt_o = rise | fall;
      EV_LOW:  evt_o = ~line_i;
      EV_HIGH: evt_o = line_i;
      default: evt_o = 1'b0;
    endcase
  end

  AST_SPARE_CODE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i > 3'd4) |-> !evt_o); // R6
  AST_NO_EDGE_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prime_q && sel_i <= 3'd2) |-> !evt_o); // R9
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] evt_i,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [NUM_LINES-1:0] wdata_i,
  output logic [NUM_LINES-1:0] rdata_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] mask_q, status_q;
  logic                 irq_q;
  logic                 wr_en, wr_dis, rd_stat, rd_any;

  assign wr_en   = req_i & we_i & (addr_i == OFS_EN);
  assign wr_dis  = req_i & we_i & (addr_i == OFS_DIS);
  assign rd_any  = req_i & ~we_i;
  assign rd_stat = rd_any & (addr_i == OFS_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_en)  mask_q <= mask_q | wdata_i;
      if (wr_dis) mask_q <= mask_q & ~wdata_i;
      // event beats the read-clear
      status_q <= (rd_stat ? '0 : status_q) | evt_i;
      irq_q    <= |(status_q & mask_q);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_any) begin
      if (addr_i == OFS_MASK)      rdata_o = mask_q;
      else if (addr_i == OFS_STAT) rdata_o = status_q;
    end
  end

  assign irq_o = irq_q;

  AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> ((mask_q & $past(wdata_i)) == $past(wdata_i))); // R2
  AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dis |=> ((mask_q & $past(wdata_i)) == '0)); // R3
  AST_READ_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stat && evt_i == '0) |=> (status_q == '0)); // R7
  AST_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R7
  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) != '0) |=> irq_q); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & mask_q) == '0) |=> !irq_q); // R8
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_LINES-1:0]       line_i,
  input  logic [SEL_W*NUM_LINES-1:0] evt_sel_i,
  input  logic                       bus_req_i,
  input  logic                       bus_we_i,
  input  logic [REG_AW-1:0]          bus_addr_i,
  input  logic [NUM_LINES-1:0]       bus_wdata_i,
  output logic [NUM_LINES-1:0]       bus_rdata_o,
  output logic                       irq_o
);
  logic [NUM_LINES-1:0] evt;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpio_evt_line u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (line_i[i]),
      .sel_i  (evt_sel_i[SEL_W*i +: SEL_W]),
      .evt_o  (evt[i])
    );
  end

  gpio_irq_regs #(.NUM_LINES(NUM_LINES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .req_i   (bus_req_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/gpio_bank_irq_test.sv
module gpio_bank_irq_test;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] line = '0;
  logic [3*N-1:0] sel = '0;
  logic         req = 1'b0, we = 1'b0;
  logic [5:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_bank_irq #(.NUM_LINES(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .evt_sel_i(sel),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h exp %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic rd(logic [5:0] a, output logic [N-1:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wr(logic [5:0] a, logic [N-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  function automatic logic [3*N-1:0] quiet_sel();
    return {N{3'd5}};
  endfunction

  function automatic logic exp_evt(int s, logic a, logic b);
    case (s)
      0: return a & ~b;
      1: return ~a & b;
      2: return a ^ b;
      3: return ~b;
      4: return b;
      default: return 1'b0;
    endcase
  endfunction

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    logic [3*N-1:0] sv;
    // R9: lines high, rising select, across reset release
    line = '1; sel = {N{3'd1}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(6'h2C, d); chk("R9 no edge after reset", d, 0);
    rd(6'h2C, d); chk("R1 status reset", d, 0);
    rd(6'h28, d); chk("R1 mask reset", d, 0);
    chk("R1 irq reset", irq, 0);
    sel = quiet_sel(); line = '0;
    @(negedge clk);
    rd(6'h2C, d);

    // R2 / R3 mask set and clear
    wr(6'h20, 4'b0101); rd(6'h28, d); chk("R2 enable", d, 4'b0101);
    wr(6'h20, 4'b0010); rd(6'h28, d); chk("R2 enable keeps", d, 4'b0111);
    wr(6'h24, 4'b0100); rd(6'h28, d); chk("R3 disable", d, 4'b0011);
    wr(6'h24, 4'b0000); rd(6'h28, d); chk("R3 zero write", d, 4'b0011);

    // R8: unmasked line 2 sets status but no irq
    sv = quiet_sel(); sv[6 +: 3] = 3'd1; sel = sv; line[2] = 1'b1;
    @(negedge clk);
    sel = quiet_sel();
    rd(6'h2C, d); chk("R8 unmasked status", d, 4'b0100);
    chk("R8 unmasked no irq", irq, 0);
    @(negedge clk); chk("R8 unmasked no irq later", irq, 0);
    line = '0; @(negedge clk); rd(6'h2C, d);

    // R7: event in the clearing read cycle is kept
    sv = quiet_sel(); sv[0 +: 3] = 3'd1; sel = sv; line[0] = 1'b1;
    rd(6'h2C, d); chk("R7 read before event", d, 0);
    sel = quiet_sel();
    rd(6'h2C, d); chk("R7 event kept", d, 4'b0001);
    rd(6'h2C, d); chk("R7 cleared", d, 0);
    line = '0; @(negedge clk); rd(6'h2C, d);

    // R5: persistent high level re-arms after clear
    sv = quiet_sel(); sv[9 +: 3] = 3'd4; sel = sv; line[3] = 1'b1;
    @(negedge clk);
    rd(6'h2C, d); chk("R5 level first", d, 4'b1000);
    rd(6'h2C, d); chk("R5 level re-armed", d, 4'b1000);
    sel = quiet_sel();
    rd(6'h2C, d); chk("R5 last level", d, 4'b1000);
    rd(6'h2C, d); chk("R5 level gone", d, 0);
    line = '0; @(negedge clk);

    // R10: writes to status/mask offsets, reads of write-only offsets
    sv = quiet_sel(); sv[3 +: 3] = 3'd2; sel = sv; line[1] = 1'b1;
    @(negedge clk);
    sel = quiet_sel();
    wr(6'h2C, 4'b1111);
    wr(6'h28, 4'b0000);
    rd(6'h2C, d); chk("R10 status write ignored", d, 4'b0010);
    rd(6'h28, d); chk("R10 mask write ignored", d, 4'b0011);
    rd(6'h20, d); chk("R10 enable reads zero", d, 0);
    rd(6'h24, d); chk("R10 disable reads zero", d, 0);
    rd(6'h3C, d); chk("R10 unused reads zero", d, 0);
    line = '0; @(negedge clk); rd(6'h2C, d);

    // sweep R4 R5 R6 R8: every line, code, level pair
    wr(6'h20, '1);
    for (int k = 0; k < N; k++) begin
      for (int s = 0; s < 8; s++) begin
        for (int p = 0; p < 4; p++) begin
          logic a, b, e;
          a = p[1]; b = p[0]; e = exp_evt(s, a, b);
          sel = quiet_sel(); line = '0; line[k] = a;
          @(negedge clk);
          rd(6'h2C, d);
          sv = quiet_sel(); sv[3*k +: 3] = 3'(s); sel = sv; line[k] = b;
          @(negedge clk);
          sel = quiet_sel();
          rd(6'h2C, d);
          chk($sformatf("R4/R5/R6 line%0d code%0d %0b->%0b status", k, s, a, b),
              d, {28'd0, 4'(e) << k});
          chk($sformatf("R8 line%0d code%0d %0b->%0b irq", k, s, a, b), irq, e);
          @(negedge clk);
          chk($sformatf("R8 line%0d code%0d irq drops", k, s), irq, 0);
        end
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule